// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst request into the run of column addresses a memory row is accessed at. A single-cycle start pulse captures an 8-bit start column, a burst-length code and an ordering bit. From the next cycle on the block presents one column per clock, together with a valid strobe, and it flags the final beat of the burst.

Bursts of 2, 4 or 8 wrap inside the aligned group of columns that contains the start column. Sequential ordering counts the low bits upward. Interleaved ordering XORs the low bits with the beat number. In full-page mode the block walks the whole 256-column row, wraps from the top column to column 0, and keeps going until a stop request arrives.

A new start pulse always restarts the sequence, even in the middle of a burst. A stop request ends any burst that is running. The length and ordering seen at the start pulse hold for the whole burst.

Top module: `burst_col_seq`

## Requirements
- R1: While reset (rstN low) is held, and after it is released with no start pulse, colValid and lastBeat are 0.
- R2: A start pulse sampled at a rising edge makes colValid 1 in the next cycle, with colOut equal to the sampled startCol (beat 0).
- R3: The burst-length code selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives full page. Codes 4, 5 and 6 behave as length 1. A burst of length L keeps colValid high for exactly L consecutive cycles, then drops it.
- R4: With seqMode 0 (sequential), beat n keeps the column bits above the low log2(L) bits equal to startCol. The low bits equal (startCol + n) mod L.
- R5: With seqMode 1 (interleave), beat n keeps the upper bits equal to startCol. The low log2(L) bits equal startCol XOR n.
- R6: lastBeat is 1 only on the final beat of a burst of length 1, 2, 4 or 8. For length 1 it is 1 in the same cycle as beat 0.
- R7: In full page the ordering rule applies to all 8 bits, so the column wraps from 255 to 0. colValid stays high with no limit, and lastBeat stays 0.
- R8: A stop request sampled at an edge while a burst is active makes colValid 0 from the next cycle. A stop request with no active burst has no effect.
- R9: A start pulse during an active burst restarts from the new start column in the next cycle. If a start pulse and a stop request arrive together, the start pulse wins.
- R10: Changes on lenCode, seqMode and startCol after the start pulse have no effect on the burst that is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| startPulse | input | 1 | Starts a burst; one cycle wide |
| startCol | input | 8 | Start column, captured with startPulse |
| lenCode | input | 3 | Burst-length code (0:1, 1:2, 2:4, 3:8, 7:full page) |
| seqMode | input | 1 | Ordering: 0 sequential, 1 interleave |
| stopReq | input | 1 | Ends the active burst |
| colOut | output | 8 | Current column address |
| colValid | output | 1 | colOut holds a burst beat |
| lastBeat | output | 1 | Current beat is the final one |

## Verification
The bench starts bursts at unaligned columns, such as 0x2D with length 8, so that the wrap point falls in the middle of the burst. A design that carried into the upper bits would show a column outside the aligned group. It runs full-page bursts across 255 in both orderings, where a design with a narrow counter or a length limit would stop early or raise lastBeat. It also applies a restart, start and stop in the same cycle, a stop with no burst, a reserved length code, and changes to the mode inputs in the middle of a burst. A design with the wrong priority or without capture registers would drop the burst or change its order partway through.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int COL_W_DEF = 8;

  localparam logic [2:0] LEN_1    = 3'd0;
  localparam logic [2:0] LEN_2    = 3'd1;
  localparam logic [2:0] LEN_4    = 3'd2;
  localparam logic [2:0] LEN_8    = 3'd3;
  localparam logic [2:0] LEN_FULL = 3'd7;

  typedef struct packed {
    logic load;  // capture start column, mode and reset beat count
    logic step;  // advance to the next beat
  } seqStrobe_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int COL_W = COL_W_DEF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [2:0]       lenCode,
  input  logic             stopReq,
  input  logic [COL_W-1:0] beatCnt,
  input  logic [COL_W-1:0] beatMask,
  output seqStrobe_t       strobes,
  output logic             colValid,
  output logic             lastBeat
);
  logic activeQ;
  logic fullQ;

  assign lastBeat = activeQ && !fullQ && (beatCnt == beatMask);
  assign colValid = activeQ;

  always_comb begin
    strobes.load = startPulse;
    strobes.step = activeQ && !startPulse && !stopReq && !lastBeat;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      fullQ   <= 1'b0;
    end else if (startPulse) begin
      activeQ <= 1'b1;
      fullQ   <= (lenCode == LEN_FULL);
    end else if (activeQ && (stopReq || lastBeat)) begin
      activeQ <= 1'b0;
    end
  end

  assert_start_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> colValid);
  assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq && !startPulse) |=> !colValid);
  assert_last_ends_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && !startPulse) |=> !colValid);
  assert_last_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> colValid);
  assert_full_no_last_R7: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && lenCode == LEN_FULL) |=> !lastBeat);
endmodule

// File: rtl/burst_seq_dpath.sv
module burst_seq_dpath
  import burst_seq_pkg::*;
#(
  parameter int COL_W = COL_W_DEF
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobes,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             seqMode,
  output logic [COL_W-1:0] beatCnt,
  output logic [COL_W-1:0] beatMask,
  output logic [COL_W-1:0] colOut
);
  logic [COL_W-1:0] baseQ;
  logic [COL_W-1:0] cntQ;
  logic [COL_W-1:0] maskQ;
  logic             ilvQ;
  logic [COL_W-1:0] nextMask;
  logic [COL_W-1:0] sumCol;
  logic [COL_W-1:0] xorCol;

  always_comb begin
    case (lenCode)
      LEN_2:    nextMask = COL_W'(1);
      LEN_4:    nextMask = COL_W'(3);
      LEN_8:    nextMask = COL_W'(7);
      LEN_FULL: nextMask = '1;
      default:  nextMask = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      cntQ  <= '0;
      maskQ <= '0;
      ilvQ  <= 1'b0;
    end else if (strobes.load) begin
      baseQ <= startCol;
      cntQ  <= '0;
      maskQ <= nextMask;
      ilvQ  <= seqMode;
    end else if (strobes.step) begin
      cntQ  <= cntQ + 1'b1;
    end
  end

  assign sumCol = baseQ + cntQ;
  assign xorCol = baseQ ^ cntQ;

  for (genvar i = 0; i < COL_W; i++) begin : g_merge
    assign colOut[i] = maskQ[i] ? (ilvQ ? xorCol[i] : sumCol[i]) : baseQ[i];
  end

  assign beatCnt  = cntQ;
  assign beatMask = maskQ;

  assert_upper_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> ((colOut & ~maskQ) == ($past(colOut) & ~maskQ)));
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = COL_W_DEF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             seqMode,
  input  logic             stopReq,
  output logic [COL_W-1:0] colOut,
  output logic             colValid,
  output logic             lastBeat
);
  seqStrobe_t       strobes;
  logic [COL_W-1:0] beatCnt;
  logic [COL_W-1:0] beatMask;

  burst_seq_ctrl #(.COL_W(COL_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .lenCode(lenCode),
    .stopReq(stopReq), .beatCnt(beatCnt), .beatMask(beatMask),
    .strobes(strobes), .colValid(colValid), .lastBeat(lastBeat)
  );

  burst_seq_dpath #(.COL_W(COL_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .startCol(startCol),
    .lenCode(lenCode), .seqMode(seqMode), .beatCnt(beatCnt),
    .beatMask(beatMask), .colOut(colOut)
  );

  assert_beat0_col_R2: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (colOut == $past(startCol)));
  assert_bit0_toggles_R4: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && !lastBeat && !startPulse && !stopReq) |=>
      (colValid && colOut[0] != $past(colOut[0])));
endmodule

// File: tb/burst_col_seq_tb_top.sv
`timescale 1ns/1ps
module burst_col_seq_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startPulse = 1'b0;
  logic [7:0] startCol = '0;
  logic [2:0] lenCode = '0;
  logic       seqMode = 1'b0;
  logic       stopReq = 1'b0;
  logic [7:0] colOut;
  logic       colValid;
  logic       lastBeat;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;
  string curTag = "R1";

  // behavioural reference state
  int refActive = 0;
  int refBase = 0;
  int refN = 0;
  int refLen = 1;   // 256 means full page
  int refIlv = 0;

  always #4 clk = ~clk;

  burst_col_seq dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .startCol(startCol),
    .lenCode(lenCode), .seqMode(seqMode), .stopReq(stopReq),
    .colOut(colOut), .colValid(colValid), .lastBeat(lastBeat)
  );

  function automatic int codeLen(input int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 256;
      default: return 1;
    endcase
  endfunction

  function automatic int refLast();
    return (refActive != 0 && refLen != 256 && refN == refLen - 1) ? 1 : 0;
  endfunction

  function automatic int refCol();
    int hi, lo;
    hi = refBase - (refBase % refLen);
    if (refIlv != 0) lo = (refBase % refLen) ^ (refN % refLen);
    else lo = ((refBase % refLen) + refN) % refLen;
    return hi + lo;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      refActive = 0;
    end else if (startPulse) begin
      refActive = 1;
      refBase = startCol;
      refN = 0;
      refLen = codeLen(lenCode);
      refIlv = seqMode;
    end else if (refActive != 0) begin
      if (stopReq || refLast() != 0) refActive = 0;
      else refN = (refN + 1) % 256;
    end
  end

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(curTag, colValid, refActive, "colValid");
      check(refActive != 0 ? curTag : "R6", lastBeat, refLast(), "lastBeat");
      if (refActive != 0) check(curTag, colOut, refCol(), "colOut");
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go(input int col, input int code, input int ilv);
    @(negedge clk);
    startPulse = 1'b1;
    startCol = 8'(col);
    lenCode = 3'(code);
    seqMode = ilv[0];
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    while (cycles < 100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 100000);
    finish();
  end

  initial begin
    idle(3);
    curTag = "R1";
    check("R1", colValid, 0, "colValid in reset");
    check("R1", lastBeat, 0, "lastBeat in reset");
    rstN = 1'b1;
    idle(3);
    check("R1", colValid, 0, "colValid idle after reset");

    curTag = "R2";  go(8'h5A, 0, 0); idle(3);
    curTag = "R3";  go(8'h13, 5, 0); idle(3);   // reserved code acts as length 1
    curTag = "R4";
    for (int code = 1; code <= 3; code++) begin
      go(8'h2D, code, 0); idle(10);
      go(8'h07, code, 0); idle(10);
    end
    curTag = "R5";
    for (int code = 1; code <= 3; code++) begin
      go(8'h2D, code, 1); idle(10);
      go(8'hF6, code, 1); idle(10);
    end
    curTag = "R6";  go(8'h01, 0, 0); go(8'h02, 0, 1); go(8'h03, 3, 0); idle(10);
    curTag = "R7";  go(8'hF8, 7, 0); idle(20);
    stopReq = 1'b1; @(negedge clk); stopReq = 1'b0; idle(3);
    go(8'hC3, 7, 1); idle(300);
    curTag = "R8";  stopReq = 1'b1; @(negedge clk); stopReq = 1'b0; idle(3);
    stopReq = 1'b1; idle(2); stopReq = 1'b0; idle(2);   // stop while idle
    go(8'h40, 3, 0); idle(2);
    stopReq = 1'b1; @(negedge clk); stopReq = 1'b0; idle(4);
    curTag = "R9";  go(8'h10, 3, 0); idle(2); go(8'h85, 2, 1); idle(6);
    go(8'h30, 7, 0); idle(3);
    @(negedge clk); startPulse = 1'b1; stopReq = 1'b1; startCol = 8'h66; lenCode = 3'd2; seqMode = 1'b0;
    @(negedge clk); startPulse = 1'b0; stopReq = 1'b0; idle(6);
    curTag = "R10";
    @(negedge clk); startPulse = 1'b1; startCol = 8'h9B; lenCode = 3'd3; seqMode = 1'b1;
    @(negedge clk); startPulse = 1'b0; startCol = 8'h00; lenCode = 3'd0; seqMode = 1'b0;
    idle(10);
    finish();
  end
endmodule